// File: doc/BRIEF.md
# Rate-Limited Global Interrupt Controller

This block gathers interrupt requests from a set of chip modules and merges them onto two global interrupt lines that can be wired open-drain. Module 0 is a built-in example source bank with two event sources: a read timeout and a read completion. The remaining modules each present a single level request that has already been qualified inside that module. Software programs a per-source enable, reads a sticky status word, and clears status with write-one-to-clear. A flags register shows which modules have a request pending. Each global line has its own module mask and its own configuration word, which sets whether the line is on and which level it drives.

Line 1 can also enforce a minimum spacing between assertions. After a line-1 interrupt has been serviced, software writes the "treated" bit of the flags register. Line 1 is then held off for a programmed number of microseconds. Line 2 never waits. The register port is a plain strobe interface: it accepts a write or a read on every cycle and never stalls. For the same reason the event inputs carry no back-pressure, and a pulse one cycle long is always captured.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads 0, and both lines are released: `irqN_oe`=0 and `irqN_o`=0.
- R2: CPU status (address 5) bit 3 is set by a one-cycle pulse on `cpu_ev_i[0]` (timeout) and bit 4 by `cpu_ev_i[1]` (done). A set bit stays set until software writes 1 to that position. Writing 0 has no effect.
- R3: If an event and a write-one-to-clear reach the same status bit on the same cycle, the bit stays set.
- R4: Flags (address 0) bit 0 is the OR of (CPU status AND CPU enable, address 6). Bits 1..N_MOD-1 follow `mod_req_i`. Flags ignore writes, except that bit 15 acts as the treated strobe, and bit 15 reads 0.
- R5: Line 2 asserts (`irq2_oe`=1) one cycle after any flag is set under its enabled mask bit (address 4). It drops one cycle after the last such flag clears.
- R6: Configuration words (address 1 for line 1, address 2 for line 2): bit 15 enables the line, and bit 14 gives the level driven while the line is active. `irqN_o` equals that level while `irqN_oe`=1, and is 0 otherwise.
- R7: A line ignores modules whose bit in its mask is 0 (address 3 for line 1, address 4 for line 2).
- R8: When flags bit 15 is written with 1 and the period field (address 1, bits 11:0) is P>0, line 1 stays released for exactly P×CLK_PER_US cycles after the write edge. It re-asserts on the next edge if a request is still pending.
- R9: With period 0, a treated write never holds line 1 off.
- R10: A read strobe returns the addressed register on `reg_rdata` one cycle later. Configuration words read back in full. Mask registers read back N_MOD bits.
- R11: CPU enable and status bits other than 3 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after the read strobe |
| cpu_ev_i | input | 2 | CPU source events: [0] timeout, [1] done |
| mod_req_i | input | N_MOD-1 | Level requests of modules 1..N_MOD-1 |
| irq1_o | output | 1 | Line 1 drive value |
| irq1_oe | output | 1 | Line 1 drive enable (0 = tri-state) |
| irq2_o | output | 1 | Line 2 drive value |
| irq2_oe | output | 1 | Line 2 drive enable (0 = tri-state) |

## Verification
Two operations can land on the same status bit in one clock: a source event that sets it and a software clear that wipes it. The bench provokes this by raising the event input during the same cycle as the clear write. It then reads the status back and expects the bit still set, while a neighbouring bit that was only cleared reads 0. A second overlap is a treated write that arrives while line 1 is still asserted. The bench expects the line to drop on the next edge and to return after exactly the programmed window, with the count of cycles made exact by the small microsecond divider.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW     = 16;
  localparam int AW     = 4;

  localparam logic [AW-1:0] A_FLAGS = 4'd0;
  localparam logic [AW-1:0] A_CFG1  = 4'd1;
  localparam logic [AW-1:0] A_CFG2  = 4'd2;
  localparam logic [AW-1:0] A_MEN1  = 4'd3;
  localparam logic [AW-1:0] A_MEN2  = 4'd4;
  localparam logic [AW-1:0] A_CSTAT = 4'd5;
  localparam logic [AW-1:0] A_CIE   = 4'd6;

  localparam int CFG_EN_BIT  = 15;
  localparam int CFG_LVL_BIT = 14;
  localparam int TREAT_BIT   = 15;

  localparam int CPU_TMO_BIT  = 3;
  localparam int CPU_DONE_BIT = 4;
  localparam logic [DW-1:0] CPU_SRC_MASK = (DW'(1) << CPU_TMO_BIT) | (DW'(1) << CPU_DONE_BIT);

  typedef struct packed {
    logic       en;
    logic       lvl;
    logic [13:0] per;
  } line_cfg_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ie_we,
  input  logic [W-1:0] ie_wdata,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] ev,
  output logic [W-1:0] ie_q,
  output logic [W-1:0] stat_q,
  output logic         active
);
  logic [W-1:0] stat_d;

  always_comb begin
    stat_d = ((stat_q & ~clr) | ev) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (ie_we) ie_q <= ie_wdata & MASK;
    end
  end

  assign active = |(stat_q & ie_q);
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int CLK_PER_US = 100,
  parameter int PER_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             treat,
  input  logic [PER_W-1:0] period,
  output logic             busy
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] cnt_q;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (treat) begin
      pre_q <= '0;
      cnt_q <= period;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  input  logic pend,
  input  logic hold,
  output logic pin_o,
  output logic oe_o
);
  logic act_q, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      act_q <= en & pend & ~hold;
      lvl_q <= lvl;
    end
  end

  assign oe_o  = act_q;
  assign pin_o = act_q & lvl_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_MOD      = 4,
  parameter int CLK_PER_US = 125,
  parameter int PER_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [1:0]       cpu_ev_i,
  input  logic [N_MOD-2:0] mod_req_i,
  output logic             irq1_o,
  output logic             irq1_oe,
  output logic             irq2_o,
  output logic             irq2_oe
);
  localparam int NL = 2;

  logic [DW-1:0]    cfg_q [NL];
  logic [N_MOD-1:0] men_q [NL];
  logic [NL-1:0]    pin_v, oe_v, pend_v, hold_v;

  logic [DW-1:0]    cpu_ev_vec, cpu_clr, cpu_ie, cpu_stat;
  logic             cpu_active;
  logic [N_MOD-1:0] flags;
  logic             treat;
  logic             thr_busy;
  logic             wr_cie;

  // place the two CPU events at their status positions
  always_comb begin
    cpu_ev_vec = '0;
    cpu_ev_vec[CPU_TMO_BIT]  = cpu_ev_i[0];
    cpu_ev_vec[CPU_DONE_BIT] = cpu_ev_i[1];
  end

  assign cpu_clr = (reg_wr_en && reg_addr == A_CSTAT) ? reg_wdata : '0;
  assign wr_cie  = reg_wr_en && reg_addr == A_CIE;
  assign treat   = reg_wr_en && reg_addr == A_FLAGS && reg_wdata[TREAT_BIT];

  irq_src_bank #(.W(DW), .MASK(CPU_SRC_MASK)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .ie_we(wr_cie), .ie_wdata(reg_wdata),
    .clr(cpu_clr), .ev(cpu_ev_vec),
    .ie_q(cpu_ie), .stat_q(cpu_stat), .active(cpu_active)
  );

  assign flags = {mod_req_i, cpu_active};

  irq_throttle #(.CLK_PER_US(CLK_PER_US), .PER_W(PER_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .treat(treat),
    .period(cfg_q[0][PER_W-1:0]), .busy(thr_busy)
  );

  genvar li;
  generate
    for (li = 0; li < NL; li++) begin : g_line
      localparam logic [AW-1:0] CFG_A = (li == 0) ? A_CFG1 : A_CFG2;
      localparam logic [AW-1:0] MEN_A = (li == 0) ? A_MEN1 : A_MEN2;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[li] <= '0;
          men_q[li] <= '0;
        end else if (reg_wr_en) begin
          if (reg_addr == CFG_A) cfg_q[li] <= reg_wdata;
          if (reg_addr == MEN_A) men_q[li] <= reg_wdata[N_MOD-1:0];
        end
      end

      assign pend_v[li] = |(flags & men_q[li]);

      if (li == 0) begin : g_thr
        assign hold_v[li] = thr_busy;
      end else begin : g_free
        assign hold_v[li] = 1'b0;
      end

      irq_pin_stage u_pin (
        .clk(clk), .rst_n(rst_n),
        .en(cfg_q[li][CFG_EN_BIT]), .lvl(cfg_q[li][CFG_LVL_BIT]),
        .pend(pend_v[li]), .hold(hold_v[li]),
        .pin_o(pin_v[li]), .oe_o(oe_v[li])
      );
    end
  endgenerate

  assign irq1_o  = pin_v[0];
  assign irq1_oe = oe_v[0];
  assign irq2_o  = pin_v[1];
  assign irq2_oe = oe_v[1];

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_FLAGS: rd_mux = DW'(flags);
      A_CFG1:  rd_mux = cfg_q[0];
      A_CFG2:  rd_mux = cfg_q[1];
      A_MEN1:  rd_mux = DW'(men_q[0]);
      A_MEN2:  rd_mux = DW'(men_q[1]);
      A_CSTAT: rd_mux = cpu_stat;
      A_CIE:   rd_mux = cpu_ie;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int N_MOD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    ev_vec,
  input logic [DW-1:0]    stat,
  input logic [N_MOD-1:0] flags,
  input logic [N_MOD-1:0] men2,
  input logic [DW-1:0]    cfg1,
  input logic [DW-1:0]    cfg2,
  input logic             busy,
  input logic             irq1_o,
  input logic             irq1_oe,
  input logic             irq2_oe
);
  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~stat) != '0) |-> $past(wr_en && addr == A_CSTAT)); // R2

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CSTAT && (wdata & ev_vec & CPU_SRC_MASK) != '0)
    |=> ((stat & $past(wdata & ev_vec & CPU_SRC_MASK)) == $past(wdata & ev_vec & CPU_SRC_MASK))); // R3

  AST_LINE2_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq2_oe |-> $past(cfg2[CFG_EN_BIT] && ((flags & men2) != '0))); // R5

  AST_HOLD_RELEASES_LINE1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !irq1_oe); // R8

  AST_LINE1_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq1_oe |-> (irq1_o == $past(cfg1[CFG_LVL_BIT]))); // R6

  AST_STAT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~CPU_SRC_MASK) == '0); // R11
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_MOD(N_MOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
  .ev_vec(cpu_ev_vec), .stat(cpu_stat), .flags(flags), .men2(men_q[1]),
  .cfg1(cfg_q[0]), .cfg2(cfg_q[1]), .busy(thr_busy),
  .irq1_o(irq1_o), .irq1_oe(irq1_oe), .irq2_oe(irq2_oe)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int NM  = 3;
  localparam int CPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  cev = '0;
  logic [NM-2:0] mreq = '0;
  logic irq1_o, irq1_oe, irq2_o, irq2_oe;

  int total = 0, bad = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  irq_aggregator #(.N_MOD(NM), .CLK_PER_US(CPU), .PER_W(12)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_rd_en(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .cpu_ev_i(cev), .mod_req_i(mreq),
    .irq1_o(irq1_o), .irq1_oe(irq1_oe), .irq2_o(irq2_o), .irq2_oe(irq2_oe)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_ev(input logic [3:0] a, input logic [15:0] d, input logic [1:0] e);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; cev = e;
    @(negedge clk);
    wr = 1'b0; cev = '0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    wr_ev(a, d, 2'b00);
  endtask

  task automatic rreg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [1:0] e);
    @(negedge clk);
    cev = e;
    @(negedge clk);
    cev = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 oe1", {15'd0, irq1_oe}, 16'd0);
    chk("R1 oe2", {15'd0, irq2_oe}, 16'd0);
    chk("R1 o1",  {15'd0, irq1_o},  16'd0);
    for (int a = 0; a < 7; a++) begin
      rreg(4'(a), rv);
      chk("R1 reg", rv, 16'd0);
    end

    // R10/R11: readback
    wreg(4'd1, 16'hA5C3); rreg(4'd1, rv); chk("R10 cfg1", rv, 16'hA5C3);
    wreg(4'd3, 16'hFFFF); rreg(4'd3, rv); chk("R10 men1", rv, 16'h0007);
    wreg(4'd6, 16'hFFFF); rreg(4'd6, rv); chk("R11 ie", rv, 16'h0018);
    wreg(4'd1, 16'h0000); wreg(4'd3, 16'h0000);

    // line 2 on, high level, CPU module only
    wreg(4'd2, 16'hC000);
    wreg(4'd4, 16'h0001);

    // R2/R4/R5: sweep enables x events
    for (int ie = 0; ie < 4; ie++) begin
      for (int ev = 0; ev < 4; ev++) begin
        wreg(4'd5, 16'hFFFF);
        wreg(4'd6, 16'(ie << 3));
        pulse(2'(ev));
        rreg(4'd5, rv); chk("R2 set", rv, 16'(ev << 3));
        rreg(4'd0, rv); chk("R4 flag0", rv, {15'd0, (ev & ie) != 0});
        chk("R5 oe2", {15'd0, irq2_oe}, {15'd0, (ev & ie) != 0});
        chk("R6 o2",  {15'd0, irq2_o},  {15'd0, (ev & ie) != 0});
        wreg(4'd5, 16'h0000);
        rreg(4'd5, rv); chk("R2 w0", rv, 16'(ev << 3));
        wreg(4'd5, 16'h0008);
        rreg(4'd5, rv); chk("R2 w1c", rv, 16'((ev & 2) << 3));
      end
    end

    // R6: polarity codes with a request pending
    wreg(4'd6, 16'h0018);
    pulse(2'b01);
    for (int c = 0; c < 4; c++) begin
      wreg(4'd2, 16'(c << 14));
      @(negedge clk);
      chk("R6 oe", {15'd0, irq2_oe}, {15'd0, c[1]});
      chk("R6 lvl", {15'd0, irq2_o}, {15'd0, c[1] & c[0]});
    end

    // R7/R4: module mask sweep with external requests
    wreg(4'd5, 16'hFFFF);
    wreg(4'd2, 16'h8000);
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 8; e++) begin
        @(negedge clk); mreq = 2'(m);
        wreg(4'd4, 16'(e));
        @(negedge clk);
        chk("R7 mask", {15'd0, irq2_oe}, {15'd0, ((m << 1) & e) != 0});
        chk("R6 low", {15'd0, irq2_o}, 16'd0);
      end
      wreg(4'd0, 16'h7FFF);
      rreg(4'd0, rv); chk("R4 ro", rv, 16'(m << 1));
    end
    @(negedge clk); mreq = '0;

    // R3: set and clear on the same edge
    wreg(4'd5, 16'hFFFF);
    pulse(2'b10);
    wr_ev(4'd5, 16'h0018, 2'b01);
    rreg(4'd5, rv); chk("R3 collide", rv, 16'h0008);

    // R8/R9: line 1 throttle
    wreg(4'd5, 16'hFFFF);
    wreg(4'd3, 16'h0001);
    pulse(2'b01);
    for (int p = 0; p < 4; p++) begin
      wreg(4'd1, 16'hC000 | 16'(p));
      @(negedge clk);
      chk("R8 pre", {15'd0, irq1_oe}, 16'd1);
      wreg(4'd0, 16'h8000);
      if (p == 0) begin
        chk("R9 nohold", {15'd0, irq1_oe}, 16'd1);
        @(negedge clk);
        chk("R9 nohold2", {15'd0, irq1_oe}, 16'd1);
      end else begin
        repeat (p * CPU) @(negedge clk);
        chk("R8 held", {15'd0, irq1_oe}, 16'd0);
        @(negedge clk);
        chk("R8 back", {15'd0, irq1_oe}, 16'd1);
        chk("R6 o1", {15'd0, irq1_o}, 16'd1);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule